// File: doc/BRIEF.md
# Bank-Set Precharge Spacing Scheduler

This block sits on the command side of a DRAM controller whose device is split into several independent bank sets. Upstream logic hands it precharge requests one at a time. Each request is either a plain precharge or a refresh-precharge, and each names a bank-set index. The block queues the requests in arrival order. It emits them as row-precharge packets on the command clock, spaced so that the device timing holds.

Two spacing rules apply at the same time. Two precharges to the same bank set must be at least `SAME_GAP` cycles apart, which is 4 by default. Two precharge packets in a row, whatever their sets, must be at least the programmed different-set gap apart, and that gap can be set from 0 to `SAME_GAP`. Each output packet carries two command slots. When the different-set gap is zero, the block may fold the next queued request into the packet of the queue head, so that both precharges act on the same clock edge. It does this only when the two requests differ in both bank set and kind.

Top module: `pch_sched`

## Requirements
- R1: After reset, both slot-valid outputs are low and `req_ready` is high.
- R2: Two issued precharges to the same bank set are at least `SAME_GAP` (4) cycles apart.
- R3: Consecutive packets are at least the sampled different-set gap apart. A request that is not blocked by R2 issues exactly when that gap expires.
- R4: A `cfg_diff_gap` value above `SAME_GAP` acts as `SAME_GAP`.
- R5: With a gap of 1 or 2, a precharge to another set issues between two same-set precharges that are 4 cycles apart. It takes the earliest legal slot, which need not be the midpoint.
- R6: Requests issue in arrival order. Each request issues exactly once, with its kind (`1` = refresh-precharge, `0` = plain) and its set unchanged.
- R7: With a gap of 0, the queue head and the next request go out in one packet, the head in slot 0 and the next request in slot 1, when they differ in set and in kind and both are legal.
- R8: No pairing takes place when the two requests share a bank set, share a kind, or the gap is not zero.
- R9: Slot 1 is never valid without slot 0, and the two slots never name the same bank set.
- R10: `cfg_diff_gap` is sampled only on edges where the queue is empty. A change made while requests are pending has no effect on them.
- R11: `req_ready` is low while `DEPTH` requests are queued. No request is lost under backpressure.
- R12: A request accepted by an idle scheduler with no spacing pending appears on the slot outputs one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_diff_gap | input | $clog2(SAME_GAP+1) | Minimum different-set spacing in cycles |
| req_valid | input | 1 | Request present |
| req_refresh | input | 1 | 1 = refresh-precharge, 0 = plain precharge |
| req_set | input | SET_W | Target bank set |
| req_ready | output | 1 | Request accepted on this edge when high |
| s0_valid | output | 1 | Slot 0 carries a command |
| s0_refresh | output | 1 | Slot 0 kind |
| s0_set | output | SET_W | Slot 0 bank set |
| s1_valid | output | 1 | Slot 1 carries a command |
| s1_refresh | output | 1 | Slot 1 kind |
| s1_set | output | SET_W | Slot 1 bank set |

## Verification
The bench drives one other-set request between two same-set requests at gaps of 1, 2 and 4. Issuing it at the midpoint, or after the second same-set request, would show up as a wrong cycle offset. For pairing, it tries a legal pair, a same-kind pair and a same-set pair behind a head that is blocked by its own set. A picker that ignored either rule would fold an illegal command into slot 1. It also changes the gap while requests are pending, and it programs a gap above the maximum. A design that sampled the gap at any time, or truncated it instead of clamping, would issue early. A full-queue run with back-to-back requests to one set would reveal a lost or duplicated request under backpressure.

// File: rtl/pch_pkg.sv
package pch_pkg;
   typedef enum logic {
      KIND_PLAIN   = 1'b0,
      KIND_REFRESH = 1'b1
   } pch_kind_e;

   // Saturating clamp of a programmed gap to the same-set limit
   function automatic int unsigned gap_clamp(input int unsigned g, input int unsigned lim);
      return (g > lim) ? lim : g;
   endfunction
endpackage

// File: rtl/pch_queue.sv
module pch_queue #(
   parameter int SET_W = 2,
   parameter int DEPTH = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  pch_pkg::pch_kind_e push_kind,
   input  logic [SET_W-1:0] push_set,
   input  logic [1:0]       pop_n,
   output logic             full,
   output logic [CNT_W-1:0] cnt,
   output logic             h0_vld,
   output pch_pkg::pch_kind_e h0_kind,
   output logic [SET_W-1:0] h0_set,
   output logic             h1_vld,
   output pch_pkg::pch_kind_e h1_kind,
   output logic [SET_W-1:0] h1_set
);
   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("pch_queue: DEPTH must be a power of two, at least 2");
   end

   pch_pkg::pch_kind_e kind_mem [DEPTH];
   logic [SET_W-1:0]   set_mem  [DEPTH];
   logic [PTR_W-1:0]   rd_q, wr_q, rd_nx;
   logic [CNT_W-1:0]   cnt_q;
   logic               do_push;

   assign rd_nx   = rd_q + PTR_W'(1);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign cnt     = cnt_q;

   assign h0_vld  = (cnt_q != '0);
   assign h0_kind = kind_mem[rd_q];
   assign h0_set  = set_mem[rd_q];
   assign h1_vld  = (cnt_q > CNT_W'(1));
   assign h1_kind = kind_mem[rd_nx];
   assign h1_set  = set_mem[rd_nx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         rd_q  <= rd_q + PTR_W'(pop_n);
         wr_q  <= wr_q + PTR_W'(do_push);
         cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(pop_n);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         kind_mem[wr_q] <= push_kind;
         set_mem[wr_q]  <= push_set;
      end
   end

   // R11
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

   // R6
   pop_within_chk: assert property (@(posedge clk) disable iff (!rst_n)
      CNT_W'(pop_n) <= cnt_q);
endmodule

// File: rtl/pch_age.sv
module pch_age #(
   parameter int SET_W    = 2,
   parameter int SAME_GAP = 4,
   localparam int NSETS   = 1 << SET_W,
   localparam int AGE_W   = $clog2(SAME_GAP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iss0_vld,
   input  logic [SET_W-1:0] iss0_set,
   input  logic             iss1_vld,
   input  logic [SET_W-1:0] iss1_set,
   input  logic [AGE_W-1:0] gap,
   output logic [NSETS-1:0] set_ok,
   output logic             any_ok
);
   localparam logic [AGE_W-1:0] SAT = AGE_W'(SAME_GAP);
   localparam logic [AGE_W-1:0] ONE = AGE_W'(1);

   if (SAME_GAP < 1) begin : g_bad_gap
      $error("pch_age: SAME_GAP must be at least 1");
   end

   logic [AGE_W-1:0] any_age_q;

   for (genvar s = 0; s < NSETS; s++) begin : g_set
      logic [AGE_W-1:0] age_q;
      logic             hit;

      assign hit = (iss0_vld && iss0_set == SET_W'(s)) ||
                   (iss1_vld && iss1_set == SET_W'(s));
      assign set_ok[s] = (age_q == SAT);

      always_ff @(posedge clk) begin
         if (!rst_n)            age_q <= SAT;
         else if (hit)          age_q <= ONE;
         else if (age_q != SAT) age_q <= age_q + ONE;
      end

      // R2
      set_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hit |-> age_q == SAT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                any_age_q <= SAT;
      else if (iss0_vld)         any_age_q <= ONE;
      else if (any_age_q != SAT) any_age_q <= any_age_q + ONE;
   end

   assign any_ok = (any_age_q >= gap);

   // R3
   any_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss0_vld |-> any_age_q >= gap);
endmodule

// File: rtl/pch_pick.sv
module pch_pick #(
   parameter int SET_W    = 2,
   parameter bit MERGE_EN = 1'b1,
   localparam int NSETS   = 1 << SET_W
) (
   input  logic             h0_vld,
   input  pch_pkg::pch_kind_e h0_kind,
   input  logic [SET_W-1:0] h0_set,
   input  logic             h1_vld,
   input  pch_pkg::pch_kind_e h1_kind,
   input  logic [SET_W-1:0] h1_set,
   input  logic [NSETS-1:0] set_ok,
   input  logic             any_ok,
   input  logic             gap_zero,
   output logic             iss0,
   output logic             iss1,
   output logic [1:0]       pop_n
);
   assign iss0 = h0_vld && set_ok[h0_set] && any_ok;

   if (MERGE_EN) begin : g_merge
      assign iss1 = iss0 && gap_zero && h1_vld &&
                    (h1_set != h0_set) && (h1_kind != h0_kind) &&
                    set_ok[h1_set];
   end else begin : g_single
      assign iss1 = 1'b0;
   end

   assign pop_n = {1'b0, iss0} + {1'b0, iss1};
endmodule

// File: rtl/pch_sched.sv
module pch_sched #(
   parameter int SET_W    = 2,
   parameter int DEPTH    = 4,
   parameter int SAME_GAP = 4,
   parameter bit MERGE_EN = 1'b1,
   localparam int NSETS   = 1 << SET_W,
   localparam int AGE_W   = $clog2(SAME_GAP + 1),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AGE_W-1:0] cfg_diff_gap,
   input  logic             req_valid,
   input  logic             req_refresh,
   input  logic [SET_W-1:0] req_set,
   output logic             req_ready,
   output logic             s0_valid,
   output logic             s0_refresh,
   output logic [SET_W-1:0] s0_set,
   output logic             s1_valid,
   output logic             s1_refresh,
   output logic [SET_W-1:0] s1_set
);
   import pch_pkg::*;

   if (SET_W < 1) begin : g_bad_set
      $error("pch_sched: SET_W must be at least 1");
   end

   logic               full;
   logic [CNT_W-1:0]   q_cnt;
   logic               h0_vld, h1_vld;
   pch_kind_e          h0_kind, h1_kind;
   logic [SET_W-1:0]   h0_set, h1_set;
   logic [1:0]         pop_n;
   logic               iss0, iss1;
   logic [NSETS-1:0]   set_ok;
   logic               any_ok;
   logic [AGE_W-1:0]   gap_q;
   logic [AGE_W-1:0]   gap_clamped;

   assign req_ready   = !full;
   assign gap_clamped = AGE_W'(gap_clamp(int'(cfg_diff_gap), SAME_GAP));

   always_ff @(posedge clk) begin
      if (!rst_n)            gap_q <= AGE_W'(SAME_GAP);
      else if (q_cnt == '0)  gap_q <= gap_clamped;
   end

   pch_queue #(.SET_W(SET_W), .DEPTH(DEPTH)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (req_valid),
      .push_kind(pch_kind_e'(req_refresh)),
      .push_set (req_set),
      .pop_n    (pop_n),
      .full     (full),
      .cnt      (q_cnt),
      .h0_vld   (h0_vld),
      .h0_kind  (h0_kind),
      .h0_set   (h0_set),
      .h1_vld   (h1_vld),
      .h1_kind  (h1_kind),
      .h1_set   (h1_set)
   );

   pch_age #(.SET_W(SET_W), .SAME_GAP(SAME_GAP)) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .iss0_vld(iss0),
      .iss0_set(h0_set),
      .iss1_vld(iss1),
      .iss1_set(h1_set),
      .gap     (gap_q),
      .set_ok  (set_ok),
      .any_ok  (any_ok)
   );

   pch_pick #(.SET_W(SET_W), .MERGE_EN(MERGE_EN)) u_pick (
      .h0_vld  (h0_vld),
      .h0_kind (h0_kind),
      .h0_set  (h0_set),
      .h1_vld  (h1_vld),
      .h1_kind (h1_kind),
      .h1_set  (h1_set),
      .set_ok  (set_ok),
      .any_ok  (any_ok),
      .gap_zero(gap_q == '0),
      .iss0    (iss0),
      .iss1    (iss1),
      .pop_n   (pop_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s0_valid   <= 1'b0;
         s0_refresh <= 1'b0;
         s0_set     <= '0;
         s1_valid   <= 1'b0;
         s1_refresh <= 1'b0;
         s1_set     <= '0;
      end else begin
         s0_valid   <= iss0;
         s0_refresh <= iss0 ? (h0_kind == KIND_REFRESH) : 1'b0;
         s0_set     <= iss0 ? h0_set : '0;
         s1_valid   <= iss1;
         s1_refresh <= iss1 ? (h1_kind == KIND_REFRESH) : 1'b0;
         s1_set     <= iss1 ? h1_set : '0;
      end
   end

   // R9
   slot_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> (s0_valid && s1_set != s0_set));

   // R7
   pair_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> s0_refresh != s1_refresh);

   // R10
   gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(q_cnt) != '0) |-> $stable(gap_q));

   // R11
   full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cnt == CNT_W'(DEPTH)) |-> !req_ready);
endmodule

// File: tb/sim_pch_sched.sv
module sim_pch_sched;
   localparam int SET_W = 2;
   localparam int GAP_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [GAP_W-1:0] cfg_diff_gap = 3'd4;
   logic             req_valid = 1'b0;
   logic             req_refresh = 1'b0;
   logic [SET_W-1:0] req_set = '0;
   logic             req_ready;
   logic             s0_valid, s0_refresh, s1_valid, s1_refresh;
   logic [SET_W-1:0] s0_set, s1_set;

   always #10 clk = ~clk;

   pch_sched u0 (
      .clk(clk), .rst_n(rst_n), .cfg_diff_gap(cfg_diff_gap),
      .req_valid(req_valid), .req_refresh(req_refresh), .req_set(req_set),
      .req_ready(req_ready),
      .s0_valid(s0_valid), .s0_refresh(s0_refresh), .s0_set(s0_set),
      .s1_valid(s1_valid), .s1_refresh(s1_refresh), .s1_set(s1_set)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int exp_gap = 4;
   int n_log = 0;
   int log_set [64];
   int log_ref [64];
   int log_slot[64];
   int log_cyc [64];
   int last_set_cyc[4];
   int last_any_cyc = -100;
   bit saw_not_ready = 1'b0;
   int accept_cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Independent spacing monitor and issue log
   initial for (int i = 0; i < 4; i++) last_set_cyc[i] = -100;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!req_ready) saw_not_ready = 1'b1;
         if (s0_valid) begin
            chk(cyc - last_set_cyc[s0_set] >= 4, "R2", "same-set spacing slot0",
                cyc - last_set_cyc[s0_set], 4);
            chk(cyc - last_any_cyc >= exp_gap, "R3", "packet spacing",
                cyc - last_any_cyc, exp_gap);
            last_set_cyc[s0_set] = cyc;
            last_any_cyc = cyc;
            if (n_log < 64) begin
               log_set[n_log] = s0_set; log_ref[n_log] = s0_refresh;
               log_slot[n_log] = 0; log_cyc[n_log] = cyc; n_log++;
            end
         end
         if (s1_valid) begin
            chk(s0_valid && s1_set != s0_set, "R9", "slot1 pairing",
                s1_set, s0_set);
            chk(cyc - last_set_cyc[s1_set] >= 4, "R2", "same-set spacing slot1",
                cyc - last_set_cyc[s1_set], 4);
            last_set_cyc[s1_set] = cyc;
            if (n_log < 64) begin
               log_set[n_log] = s1_set; log_ref[n_log] = s1_refresh;
               log_slot[n_log] = 1; log_cyc[n_log] = cyc; n_log++;
            end
         end
      end
   end

   // Caller stands at a negedge; returns at a negedge after the transfer
   task automatic push(input bit rf, input int st);
      req_valid = 1'b1; req_refresh = rf; req_set = SET_W'(st);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      accept_cyc = cyc;
   endtask

   task automatic finish_push();
      req_valid = 1'b0;
   endtask

   task automatic start(input int gap_cfg, input int gap_exp);
      @(negedge clk);
      cfg_diff_gap = GAP_W'(gap_cfg);
      exp_gap = gap_exp;
      repeat (3) @(negedge clk);
      n_log = 0;
   endtask

   task automatic drain(input int n, input string tag);
      int w = 0;
      while (n_log < n && w < 80) begin @(negedge clk); w++; end
      repeat (10) @(negedge clk);
      chk(n_log == n, tag, "issued command count", n_log, n);
   endtask

   task automatic expect_entry(input int i, input int st, input int rf,
                               input int sl, input int off, input string tag);
      chk(log_set[i] == st, tag, $sformatf("entry %0d set", i), log_set[i], st);
      chk(log_ref[i] == rf, tag, $sformatf("entry %0d kind", i), log_ref[i], rf);
      chk(log_slot[i] == sl, tag, $sformatf("entry %0d slot", i), log_slot[i], sl);
      chk(log_cyc[i] - log_cyc[0] == off, tag, $sformatf("entry %0d offset", i),
          log_cyc[i] - log_cyc[0], off);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!s0_valid && !s1_valid, "R1", "slots idle after reset", s0_valid, 0);
      chk(req_ready, "R1", "ready after reset", req_ready, 1);
   endtask

   task automatic t_same_set();
      start(4, 4);
      push(0, 0); push(0, 0); finish_push();
      drain(2, "R2");
      expect_entry(0, 0, 0, 0, 0, "R2");
      expect_entry(1, 0, 0, 0, 4, "R2");
   endtask

   task automatic t_latency();
      int acc;
      start(4, 4);
      push(1, 2); acc = accept_cyc; finish_push();
      drain(1, "R12");
      chk(log_cyc[0] - acc == 1, "R12", "accept to slot delay", log_cyc[0] - acc, 1);
      chk(log_ref[0] == 1, "R6", "kind preserved", log_ref[0], 1);
   endtask

   task automatic t_insert(input int g, input string tag);
      start(g, g);
      push(0, 0); push(0, 1); push(0, 0); finish_push();
      drain(3, tag);
      expect_entry(0, 0, 0, 0, 0, tag);
      expect_entry(1, 1, 0, 0, (g == 0) ? 1 : g, tag);
      expect_entry(2, 0, 0, 0, (g > 4) ? 8 : ((g == 4) ? 8 : 4), tag);
   endtask

   task automatic t_clamp();
      start(7, 4);
      push(0, 2); push(0, 3); finish_push();
      drain(2, "R4");
      expect_entry(1, 3, 0, 0, 4, "R4");
   endtask

   task automatic t_merge();
      start(0, 0);
      push(0, 1); push(1, 1); push(0, 2); finish_push();
      drain(3, "R7");
      expect_entry(0, 1, 0, 0, 0, "R7");
      expect_entry(1, 1, 1, 0, 4, "R7");
      expect_entry(2, 2, 0, 1, 4, "R7");
   endtask

   task automatic t_no_merge_kind();
      start(0, 0);
      push(0, 1); push(0, 1); push(0, 2); finish_push();
      drain(3, "R8");
      expect_entry(1, 1, 0, 0, 4, "R8");
      expect_entry(2, 2, 0, 0, 5, "R8");
   endtask

   task automatic t_no_merge_set();
      start(0, 0);
      push(0, 3); push(1, 3); push(0, 3); finish_push();
      drain(3, "R8");
      expect_entry(1, 3, 1, 0, 4, "R8");
      expect_entry(2, 3, 0, 0, 8, "R8");
   endtask

   task automatic t_no_merge_gap();
      start(1, 1);
      push(0, 1); push(1, 1); push(0, 2); finish_push();
      drain(3, "R8");
      expect_entry(1, 1, 1, 0, 4, "R8");
      expect_entry(2, 2, 0, 0, 5, "R8");
   endtask

   task automatic t_cfg_hold();
      start(4, 4);
      push(0, 0);
      cfg_diff_gap = 3'd0;
      push(0, 1); finish_push();
      drain(2, "R10");
      expect_entry(1, 1, 0, 0, 4, "R10");
      // idle again: new value of 0 now applies
      exp_gap = 0;
      repeat (3) @(negedge clk);
      n_log = 0;
      push(0, 2); push(0, 3); finish_push();
      drain(2, "R10");
      expect_entry(1, 3, 0, 0, 1, "R10");
   endtask

   task automatic t_backpressure();
      start(4, 4);
      saw_not_ready = 1'b0;
      for (int i = 0; i < 6; i++) push(i % 2, 3);
      finish_push();
      drain(6, "R11");
      chk(saw_not_ready, "R11", "ready dropped when full", saw_not_ready, 1);
      for (int i = 0; i < 6; i++) expect_entry(i, 3, i % 2, 0, 4 * i, "R11");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_same_set();
      t_latency();
      t_insert(1, "R5");
      t_insert(2, "R5");
      t_insert(4, "R3");
      t_insert(0, "R3");
      t_clamp();
      t_merge();
      t_no_merge_kind();
      t_no_merge_set();
      t_no_merge_gap();
      t_cfg_hold();
      t_backpressure();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule